// File: doc/BRIEF.md
# Segmented Carry-Select Adder with Accumulator

This block adds two operands and an incoming carry, using a carry-select structure. The bit positions are grouped into five-cell blocks. Each cell works out its sum and carry twice, once assuming a carry of 0 arrives and once assuming a carry of 1. The two results ripple along two parallel chains inside the block. The true carry entering the block then picks one chain for all five sums and for the block's outgoing carry. Pairs of blocks form ten-cell segments, and a width that is not a multiple of ten ends in a one-block segment. As a result, only the block boundaries lie on the path the true carry has to travel.

A per-cell start mask lets a new carry chain begin at any cell. At such a cell both assumed carries take the external carry input, and the cells below it have no effect on it. A mode input chooses between two uses. In plain mode the block is a combinational adder. In accumulate mode the registered sum takes the place of the first operand, so the second operand is added to a running total on every clock edge.

Top module: `csel_accum`

## Requirements
- R1: With `acc_mode` low and `chain_start` all zero, `{carry_out, sum_out}` equals `op_a + op_b + carry_in` in the same cycle, with no clock edge in between.
- R2: Each cell produces a sum and a carry-out for an assumed carry-in of 0 and of 1. The assumed-1 carry is never lower than the assumed-0 carry. The true carry entering a block picks which set of results the block uses.
- R3: The true carry is resolved only at five-cell block boundaries, with two blocks to a segment. A carry starting at cell 0 travels through every boundary: all-ones plus a carry-in of 1 gives a sum of 0 and `carry_out` = 1.
- R4: When `chain_start[k]` is 1, the carry entering cell k equals `carry_in`, and the cells below k do not affect it. Example, with width 25: `op_a` all ones, `op_b` = 1, `carry_in` = 0 and only bit 7 set gives a sum of 0x1FFFF80 and a carry of 0.
- R5: The sum register loads the adder result on every rising edge while `rst_n` is high, in either mode. When `acc_mode` is high, the register replaces `op_a` as an operand and drives `sum_out`, so the total grows by `op_b + carry_in` on each edge.
- R6: When `acc_mode` is high, `carry_out` is the carry captured at the same edge as the sum. It does not follow the current inputs combinationally.
- R7: A rising edge with `rst_n` low clears the sum register and the registered carry to 0.
- R8: `WIDTH` must be a multiple of 5. When it is not a multiple of 10, the last segment holds one block. With the default width of 25, `carry_out` is the carry leaving cell 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_mode | input | 1 | 1 = registered accumulator, 0 = combinational adder |
| op_a | input | WIDTH | First operand (ignored when accumulating) |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | External carry into cell 0 and into every chain-start cell |
| chain_start | input | WIDTH | Per-cell mask; a 1 starts a fresh carry chain at that cell |
| sum_out | output | WIDTH | Sum, combinational or registered according to `acc_mode` |
| carry_out | output | 1 | Final carry, combinational or registered according to `acc_mode` |

## Verification
The arithmetic property assumes the start mask is all zero. It says nothing about masked vectors, which the bench checks against its own per-cell ripple model instead. The accumulate and reset properties assume that reset has been released for at least one edge before a registered value is judged, and the bench holds reset low from time zero. Inputs change only on falling edges, so every property sees stable operands, and the bench draws masks sparse enough that chains both start and cross block boundaries.

// File: rtl/csel_pkg.sv
// Package: shared sizes and the dual-result record for the carry-select adder.
// Assumes: block and segment sizes are fixed by the architecture; only the total width varies.
package csel_pkg;
    localparam int BLK_CELLS = 5;                     // cells resolved together
    localparam int SEG_BLKS  = 2;                     // blocks per segment
    localparam int SEG_CELLS = BLK_CELLS * SEG_BLKS;  // cells per segment

    // Results of one cell for both assumed carry-in values.
    typedef struct packed {
        logic sum0;
        logic sum1;
        logic cout0;
        logic cout1;
    } dual_res_t;
endpackage

// File: rtl/csel_cell.sv
// Module: one bit-cell. Computes sum and carry for two assumed carry inputs in parallel.
// Assumes: both assumed carries are supplied by the enclosing block's chains.
module csel_cell
    import csel_pkg::*;
(
    input  logic      a,
    input  logic      b,
    input  logic      cin0,
    input  logic      cin1,
    output dual_res_t res
);
    logic prop;
    logic gen;

    // Generate/propagate terms and both outcomes of the full add.
    always_comb begin
        prop      = a ^ b;
        gen       = a & b;
        res.sum0  = prop ^ cin0;
        res.sum1  = prop ^ cin1;
        res.cout0 = gen | (prop & cin0);
        res.cout1 = gen | (prop & cin1);
    end
endmodule

// File: rtl/csel_block.sv
// Module: five-cell block with two precomputed carry chains and one select point.
// Assumes: blk_cin is the true carry arriving from the block below; start bits force
//          both chains to ext_cin at the flagged cell.
module csel_block
    import csel_pkg::*;
(
    input  logic [BLK_CELLS-1:0] a,
    input  logic [BLK_CELLS-1:0] b,
    input  logic [BLK_CELLS-1:0] start,
    input  logic                 ext_cin,
    input  logic                 blk_cin,
    output logic [BLK_CELLS-1:0] sum,
    output logic                 blk_cout
);
    localparam int LAST = BLK_CELLS - 1;

    dual_res_t res [BLK_CELLS];

    for (genvar i = 0; i < BLK_CELLS; i++) begin : g_cell
        logic ci0;
        logic ci1;
        if (i == 0) begin : g_first
            // Chains begin at 0 and 1 unless a new chain starts here.
            assign ci0 = start[i] ? ext_cin : 1'b0;
            assign ci1 = start[i] ? ext_cin : 1'b1;
        end else begin : g_next
            // Each chain's own carry feeds forward unless a new chain starts here.
            assign ci0 = start[i] ? ext_cin : res[i-1].cout0;
            assign ci1 = start[i] ? ext_cin : res[i-1].cout1;
        end
        csel_cell u_cell (
            .a    (a[i]),
            .b    (b[i]),
            .cin0 (ci0),
            .cin1 (ci1),
            .res  (res[i])
        );
        // True block carry picks the precomputed sum.
        assign sum[i] = blk_cin ? res[i].sum1 : res[i].sum0;
    end

    // True block carry picks the precomputed outgoing carry.
    assign blk_cout = blk_cin ? res[LAST].cout1 : res[LAST].cout0;

    // Chain ordering and chain-start independence checks.
    always_comb begin
        for (int i = 0; i < BLK_CELLS; i++) begin
            assert_chain_order_R2: assert (!res[i].cout0 || res[i].cout1)
                else $error("assumed-1 carry below assumed-0 carry at cell %0d", i);
            assert_start_indep_R4: assert (!start[0] || (res[i].sum0 == res[i].sum1))
                else $error("chain start at cell 0 left sums dependent on block carry");
        end
    end
endmodule

// File: rtl/csel_segment.sv
// Module: a segment of one or two five-cell blocks; the carry is resolved between them.
// Assumes: NBLK is 1 or 2; ports are NBLK*BLK_CELLS bits wide.
module csel_segment
    import csel_pkg::*;
#(
    parameter int NBLK = SEG_BLKS
) (
    input  logic [NBLK*BLK_CELLS-1:0] a,
    input  logic [NBLK*BLK_CELLS-1:0] b,
    input  logic [NBLK*BLK_CELLS-1:0] start,
    input  logic                      ext_cin,
    input  logic                      seg_cin,
    output logic [NBLK*BLK_CELLS-1:0] sum,
    output logic                      seg_cout
);
    logic [NBLK:0] bc;

    // True carry enters the lowest block.
    assign bc[0] = seg_cin;

    for (genvar k = 0; k < NBLK; k++) begin : g_blk
        csel_block u_blk (
            .a        (a[k*BLK_CELLS +: BLK_CELLS]),
            .b        (b[k*BLK_CELLS +: BLK_CELLS]),
            .start    (start[k*BLK_CELLS +: BLK_CELLS]),
            .ext_cin  (ext_cin),
            .blk_cin  (bc[k]),
            .sum      (sum[k*BLK_CELLS +: BLK_CELLS]),
            .blk_cout (bc[k+1])
        );
    end

    // Carry leaving the top block leaves the segment.
    assign seg_cout = bc[NBLK];
endmodule

// File: rtl/csel_accum.sv
// Module: top of the segmented carry-select adder with optional accumulator feedback.
// Assumes: WIDTH is a multiple of BLK_CELLS; synchronous active-low reset; inputs
//          stable around the rising edge.
module csel_accum
    import csel_pkg::*;
#(
    parameter int WIDTH = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_mode,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    input  logic [WIDTH-1:0] chain_start,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);
    localparam int  NSEG      = (WIDTH + SEG_CELLS - 1) / SEG_CELLS;
    localparam bit  HALF_LAST = (WIDTH % SEG_CELLS) != 0;

    logic [WIDTH-1:0] acc_q;
    logic             acc_c_q;
    logic [WIDTH-1:0] eff_a;
    logic [WIDTH-1:0] comb_sum;
    logic [NSEG:0]    seg_c;
    logic             past_ok;

    // Accumulator feedback replaces operand A.
    assign eff_a    = acc_mode ? acc_q : op_a;
    assign seg_c[0] = carry_in;

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        localparam int NB = (HALF_LAST && (g == NSEG - 1)) ? 1 : SEG_BLKS;
        localparam int LO = g * SEG_CELLS;
        localparam int SW = NB * BLK_CELLS;
        csel_segment #(.NBLK(NB)) u_seg (
            .a        (eff_a[LO +: SW]),
            .b        (op_b[LO +: SW]),
            .start    (chain_start[LO +: SW]),
            .ext_cin  (carry_in),
            .seg_cin  (seg_c[g]),
            .sum      (comb_sum[LO +: SW]),
            .seg_cout (seg_c[g+1])
        );
    end

    // Sum and carry register, loaded every edge, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            acc_c_q <= 1'b0;
        end else begin
            acc_q   <= comb_sum;
            acc_c_q <= seg_c[NSEG];
        end
    end

    // Output path: bypass in plain mode, registered in accumulate mode.
    assign sum_out   = acc_mode ? acc_q   : comb_sum;
    assign carry_out = acc_mode ? acc_c_q : seg_c[NSEG];

    // Marks that the previous edge was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    initial begin
        assert_width_R8: assert (WIDTH % BLK_CELLS == 0)
            else $error("WIDTH must be a multiple of %0d", BLK_CELLS);
    end

    assert_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_start == '0) |->
        ({seg_c[NSEG], comb_sum} ==
         (WIDTH+1)'(eff_a) + (WIDTH+1)'(op_b) + (WIDTH+1)'(carry_in)))
        else $error("segmented sum differs from binary sum");

    assert_acc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && acc_mode) |-> (sum_out == $past(comb_sum)))
        else $error("accumulated sum is not the previous result");

    assert_acc_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && acc_mode) |-> (carry_out == $past(seg_c[NSEG])))
        else $error("registered carry is not the previous carry");

    assert_reset_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !past_ok |-> (acc_q == '0 && !acc_c_q))
        else $error("register not cleared by reset");
endmodule

// File: tb/test_csel_accum.sv
// Bench: vector table for plain-mode sums, random runs against a ripple model,
// then directed chain-start, accumulate and reset sequences.
module test_csel_accum;
    localparam int W  = 25;
    localparam int NV = 11;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         acc_mode;
    logic [W-1:0] op_a;
    logic [W-1:0] op_b;
    logic         carry_in;
    logic [W-1:0] chain_start;
    logic [W-1:0] sum_out;
    logic         carry_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    csel_accum #(.WIDTH(W)) i_csel_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_mode    (acc_mode),
        .op_a        (op_a),
        .op_b        (op_b),
        .carry_in    (carry_in),
        .chain_start (chain_start),
        .sum_out     (sum_out),
        .carry_out   (carry_out)
    );

    always #5 clk = ~clk;

    // Packs one vector: a, b, cin and the expected {carry, sum}.
    function automatic logic [76:0] mk(logic [W-1:0] a, logic [W-1:0] b, logic cin);
        logic [W:0] e;
        e = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        return {a, b, cin, e};
    endfunction

    localparam logic [76:0] VECS [NV] = '{
        mk(25'h0000000, 25'h0000000, 1'b0),
        mk(25'h1FFFFFF, 25'h0000000, 1'b1),
        mk(25'h1FFFFFF, 25'h1FFFFFF, 1'b1),
        mk(25'h000001F, 25'h0000001, 1'b0),
        mk(25'h00003FF, 25'h0000001, 1'b0),
        mk(25'h0007FFF, 25'h0000000, 1'b1),
        mk(25'h00FFFFF, 25'h0000001, 1'b0),
        mk(25'h1555555, 25'h0AAAAAA, 1'b1),
        mk(25'h1234567, 25'h0FEDCBA, 1'b0),
        mk(25'h0F0F0F0, 25'h1E1E1E1, 1'b1),
        mk(25'h1000000, 25'h1000000, 1'b0)
    };

    // Ripple model: a set mask bit reloads the carry from the external carry-in.
    function automatic logic [W:0] ref_add(logic [W-1:0] a, logic [W-1:0] b,
                                           logic cin, logic [W-1:0] m);
        logic [W:0] r;
        logic       c;
        c = cin;
        for (int i = 0; i < W; i++) begin
            if (m[i]) c = cin;
            r[i] = a[i] ^ b[i] ^ c;
            c    = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
        end
        r[W] = c;
        return r;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; acc_mode = 1'b1; op_a = '0; op_b = '0;
        carry_in = 1'b0; chain_start = '0;
        repeat (2) @(negedge clk);
        #1;
        check("R7 reset sum", 64'(sum_out), 64'd0);
        check("R7 reset carry", 64'(carry_out), 64'd0);

        @(negedge clk);
        rst_n = 1'b1; acc_mode = 1'b0;

        // Table walk: plain mode, no chain starts.
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            op_a = VECS[v][76:52]; op_b = VECS[v][51:27]; carry_in = VECS[v][26];
            #1;
            check($sformatf("R1/R3 sum vec%0d", v), 64'(sum_out), 64'(VECS[v][24:0]));
            check($sformatf("R1/R8 carry vec%0d", v), 64'(carry_out), 64'(VECS[v][25]));
        end

        // Random vectors with and without sparse chain starts.
        for (int n = 0; n < 400; n++) begin
            logic [W:0] e;
            @(negedge clk);
            op_a = W'($urandom); op_b = W'($urandom); carry_in = 1'($urandom);
            chain_start = (n % 2 == 0) ? '0 : W'($urandom & $urandom & $urandom);
            e = ref_add(op_a, op_b, carry_in, chain_start);
            #1;
            check((n % 2 == 0) ? "R2 random sum" : "R4 random masked sum",
                  64'({carry_out, sum_out}), 64'(e));
        end

        // Chain start at cell 7 cuts the ripple from below.
        @(negedge clk);
        op_a = 25'h1FFFFFF; op_b = 25'h0000001; carry_in = 1'b0;
        chain_start = 25'h0000080;
        #1;
        check("R4 start cell 7 sum", 64'(sum_out), 64'h1FFFF80);
        check("R4 start cell 7 carry", 64'(carry_out), 64'd0);

        // Chain start at a block boundary cell with carry-in 1.
        @(negedge clk);
        op_a = 25'h00003FF; op_b = 25'h0000000; carry_in = 1'b1;
        chain_start = 25'h0000020;
        #1;
        check("R4 start cell 5 sum", 64'(sum_out), 64'h0000000 | 64'h0000000 + 64'h0000400);
        check("R4 start cell 5 carry", 64'(carry_out), 64'd0);

        // Accumulate sequence.
        @(negedge clk);
        rst_n = 1'b0; acc_mode = 1'b1; op_b = '0; carry_in = 1'b0; chain_start = '0;
        @(negedge clk);
        rst_n = 1'b1; op_b = 25'd5;
        #1;
        check("R7 cleared before accumulate", 64'(sum_out), 64'd0);
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            #1;
            check($sformatf("R5 total step %0d", k), 64'(sum_out), 64'(5 * k));
        end
        op_b = 25'h1FFFFFF;
        #1;
        check("R6 carry not combinational", 64'(carry_out), 64'd0);
        check("R5 sum held until edge", 64'(sum_out), 64'd15);
        @(negedge clk);
        #1;
        check("R5 wrapped total", 64'(sum_out), 64'hE);
        check("R6 registered carry", 64'(carry_out), 64'd1);
        op_b = '0; carry_in = 1'b1;
        @(negedge clk);
        #1;
        check("R5 carry-in adds", 64'(sum_out), 64'hF);
        check("R6 carry after no overflow", 64'(carry_out), 64'd0);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check("R7 mid-run reset sum", 64'(sum_out), 64'd0);
        check("R7 mid-run reset carry", 64'(carry_out), 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule